// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block gathers up to N event inputs (16 by default) and turns selected signal transitions into interrupt requests on two independent active-low outputs. Every input first passes through a two-flop synchronizer. A shared edge-select register then chooses, for each input, rising-edge detection, falling-edge detection, both, or neither. A detected event is latched into the status register of each line on which that input is unmasked. Each line has its own status/mask pair, so two separate agents can each own one line and handle interrupts without disturbing the other.

All state is reached through a byte-wide register port. The port has one address, write data, a write strobe, a read strobe and registered read data. A control bit selects how status is cleared. In one setting, reading a status byte clears the bits it returned. In the other, software clears a bit by writing a 1 to it. An 8-bit primary view per line reports which secondary banks are requesting on that line. This block's own request is placed at a parameterised bit position, and the requests of peer banks enter through input ports.

Top module: `sec_irq_ctrl`

Register addresses (byte, 6-bit): 0x00 control (bit 0 = clear-on-read, reset 0); 0x01 primary view line 1; 0x02 primary view line 2; 0x08 status line 1; 0x0C mask line 1; 0x10 status line 2; 0x14 mask line 2; 0x18 edge select. Each register group is little-endian over consecutive bytes.

## Requirements
- R1: The edge-select register holds two bits per input. Input i uses flat bit 2i+1 (rise enable) and flat bit 2i (fall enable), which places it in byte i/4 at offset 2*(i mod 4) from address 0x18.
- R2: An input whose two edge bits are both 0 never sets a status bit. After reset every edge bit is 0.
- R3: Line 1 and line 2 each have their own status and mask registers and share the edge-select register. An event sets the status bit only on the lines where that input is unmasked.
- R4: A mask bit of 1 disables its input for that line. Masks reset to all ones, and a line whose mask is all ones never asserts its output.
- R5: irq1_n and irq2_n are low exactly when (status AND NOT mask) of their line is non-zero. An input transition reaches status at the third rising clock edge after it is applied.
- R6: With control bit 0 set (clear-on-read), a read of a status byte clears the bits it returned, and writes to status bytes have no effect.
- R7: With control bit 0 clear (write-one-to-clear), writing a 1 to a status bit clears it, writing a 0 leaves it, and reads do not clear.
- R8: Status and mask registers occupy ceil(N/8) bytes with bit n in byte n/8, bit n mod 8. Bits at or above N, and unmapped addresses, read as 0.
- R9: An event that lands in the same cycle as a clearing read or write of its status bit leaves that bit set.
- R10: The primary view of each line shows peer requests masked by the BANK_PRESENT parameter. This block's own line request appears at bit SELF_POS, replacing the peer input at that position.
- R11: Read data is registered and valid in the cycle after rd_en is sampled. It holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | N | Asynchronous event inputs |
| peer_l1 | input | 8 | Requests of other banks on line 1 |
| peer_l2 | input | 8 | Requests of other banks on line 2 |
| addr | input | 6 | Register byte address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq1_n | output | 1 | Line 1 interrupt, active low |
| irq2_n | output | 1 | Line 2 interrupt, active low |

## Verification
The two functions that can fall in the same cycle are the capture of a detected edge into a status bit and a clearing access to that same bit. To provoke the overlap, the bench first sets a status bit. It then applies a new transition on that input and times a write-one-to-clear so that the write is sampled on exactly the third clock edge after the transition, the edge on which the new event is latched. The bit must read back as 1 and the line must still be asserted. Around this directed case, random input toggles are interleaved with random mask, edge, control and status accesses, and every read and interrupt level is compared against a bench model of both lines.

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N = 16,
  parameter logic [7:0] BANK_PRESENT = 8'h2F,
  parameter int SELF_POS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic [7:0]   peer_l1,
  input  logic [7:0]   peer_l2,
  input  logic [5:0]   addr,
  input  logic [7:0]   wr_data,
  input  logic         wr_en,
  input  logic         rd_en,
  output logic [7:0]   rd_data,
  output logic         irq1_n,
  output logic         irq2_n
);
  localparam int NB = (N + 7) / 8;
  localparam int EB = (2 * N + 7) / 8;
  localparam logic [5:0] A_CTRL = 6'h00, A_PRI1 = 6'h01, A_PRI2 = 6'h02;
  localparam logic [5:0] A_ST1 = 6'h08, A_MK1 = 6'h0C, A_ST2 = 6'h10, A_MK2 = 6'h14, A_EDG = 6'h18;

  logic [N-1:0]   s1, s2, s3;
  logic [N-1:0]   st1, st2, mk1, mk2;
  logic [2*N-1:0] edg;
  logic           cor;
  logic [N-1:0]   rise, fall, ev, clr1, clr2, en_any;
  logic [3:0][7:0] st1_b, st2_b, mk1_b, mk2_b;
  logic [7:0][7:0] edg_b;
  logic           own1, own2;
  logic [7:0]     pri1, pri2, rmux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else {s1, s2, s3} <= {evt_in, s1, s2};

  assign rise = s2 & ~s3;
  assign fall = s3 & ~s2;

  always_comb
    for (int i = 0; i < N; i++) begin
      ev[i]     = (rise[i] & edg[2*i+1]) | (fall[i] & edg[2*i]);
      en_any[i] = edg[2*i+1] | edg[2*i];
      clr1[i]   = (addr == 6'(A_ST1 + i/8)) && ((wr_en && !cor && wr_data[i%8]) || (rd_en && cor));
      clr2[i]   = (addr == 6'(A_ST2 + i/8)) && ((wr_en && !cor && wr_data[i%8]) || (rd_en && cor));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st1 <= '0; st2 <= '0; mk1 <= '1; mk2 <= '1; edg <= '0; cor <= 1'b0;
    end else begin
      st1 <= (st1 & ~clr1) | (ev & ~mk1);
      st2 <= (st2 & ~clr2) | (ev & ~mk2);
      if (wr_en && addr == A_CTRL) cor <= wr_data[0];
      for (int i = 0; i < N; i++) begin
        if (wr_en && addr == 6'(A_MK1 + i/8)) mk1[i] <= wr_data[i%8];
        if (wr_en && addr == 6'(A_MK2 + i/8)) mk2[i] <= wr_data[i%8];
      end
      for (int i = 0; i < 2*N; i++)
        if (wr_en && addr == 6'(A_EDG + i/8)) edg[i] <= wr_data[i%8];
    end

  assign own1   = |(st1 & ~mk1);
  assign own2   = |(st2 & ~mk2);
  assign irq1_n = ~own1;
  assign irq2_n = ~own2;

  assign pri1 = BANK_PRESENT & ((peer_l1 & ~(8'd1 << SELF_POS)) | (8'(own1) << SELF_POS));
  assign pri2 = BANK_PRESENT & ((peer_l2 & ~(8'd1 << SELF_POS)) | (8'(own2) << SELF_POS));

  assign st1_b = 32'(st1);
  assign st2_b = 32'(st2);
  assign mk1_b = 32'(mk1);
  assign mk2_b = 32'(mk2);
  assign edg_b = 64'(edg);

  always_comb begin
    rmux = 8'h00;
    if (addr == A_CTRL) rmux = {7'b0, cor};
    else if (addr == A_PRI1) rmux = pri1;
    else if (addr == A_PRI2) rmux = pri2;
    else if (addr[5:2] == A_ST1[5:2] && 32'(addr[1:0]) < NB) rmux = st1_b[addr[1:0]];
    else if (addr[5:2] == A_MK1[5:2] && 32'(addr[1:0]) < NB) rmux = mk1_b[addr[1:0]];
    else if (addr[5:2] == A_ST2[5:2] && 32'(addr[1:0]) < NB) rmux = st2_b[addr[1:0]];
    else if (addr[5:2] == A_MK2[5:2] && 32'(addr[1:0]) < NB) rmux = mk2_b[addr[1:0]];
    else if (addr[5:3] == A_EDG[5:3] && 32'(addr[2:0]) < EB) rmux = edg_b[addr[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) rd_data <= rmux;

  p_no_edge_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st1 & ~$past(st1)) & ~$past(en_any)) == '0 && ((st2 & ~$past(st2)) & ~$past(en_any)) == '0);

  p_masked_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st1 & ~$past(st1)) & $past(mk1)) == '0 && ((st2 & ~$past(st2)) & $past(mk2)) == '0);

  p_full_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mk1 |-> irq1_n) and (&mk2 |-> irq2_n));

  p_clear_needs_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st1) & ~st1) != '0 || ($past(st2) & ~st2) != '0) |-> $past(wr_en || rd_en));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: tb/tb_sec_irq_ctrl.sv
module tb_sec_irq_ctrl;
  localparam int N = 16;
  localparam logic [7:0] PRES = 8'h2F;
  localparam int SELF = 5;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt_in = '0;
  logic [7:0] peer_l1 = 0, peer_l2 = 0, wr_data = 0, rd_data;
  logic [5:0] addr = 0;
  logic wr_en = 0, rd_en = 0, irq1_n, irq2_n;
  int checks = 0, errors = 0;

  logic [N-1:0] m_st1, m_st2, m_mk1, m_mk2, m_prev;
  logic [2*N-1:0] m_edg;
  logic m_cor;

  sec_irq_ctrl #(.N(N), .BANK_PRESENT(PRES), .SELF_POS(SELF)) dut (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(logic [31:0] v, int b);
    return v[8*b +: 8];
  endfunction

  function automatic logic [7:0] mread(logic [5:0] a);
    logic o1 = |(m_st1 & ~m_mk1), o2 = |(m_st2 & ~m_mk2);
    logic [7:0] p1 = PRES & ((peer_l1 & ~(8'd1 << SELF)) | (8'(o1) << SELF));
    logic [7:0] p2 = PRES & ((peer_l2 & ~(8'd1 << SELF)) | (8'(o2) << SELF));
    case (a)
      6'h00: return {7'b0, m_cor};
      6'h01: return p1;
      6'h02: return p2;
      6'h08, 6'h09: return byte_of(32'(m_st1), a - 8);
      6'h0C, 6'h0D: return byte_of(32'(m_mk1), a - 12);
      6'h10, 6'h11: return byte_of(32'(m_st2), a - 16);
      6'h14, 6'h15: return byte_of(32'(m_mk2), a - 20);
      6'h18, 6'h19, 6'h1A, 6'h1B: return byte_of(m_edg, a - 24);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_irq(string tag);
    check({tag, " irq1_n"}, irq1_n, ~|(m_st1 & ~m_mk1));
    check({tag, " irq2_n"}, irq2_n, ~|(m_st2 & ~m_mk2));
  endtask

  task automatic bus_wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    for (int i = 0; i < N; i++) begin
      if (a == 6'(8 + i/8) && !m_cor && d[i%8]) m_st1[i] = 0;
      if (a == 6'(16 + i/8) && !m_cor && d[i%8]) m_st2[i] = 0;
      if (a == 6'(12 + i/8)) m_mk1[i] = d[i%8];
      if (a == 6'(20 + i/8)) m_mk2[i] = d[i%8];
    end
    for (int i = 0; i < 2*N; i++) if (a == 6'(24 + i/8)) m_edg[i] = d[i%8];
    if (a == 0) m_cor = d[0];
  endtask

  task automatic bus_rd(string tag, logic [5:0] a);
    logic [7:0] e;
    @(negedge clk); addr = a; rd_en = 1; e = mread(a);
    @(negedge clk); rd_en = 0;
    check(tag, rd_data, e);
    if (m_cor) for (int i = 0; i < N; i++) begin
      if (a == 6'(8 + i/8)) m_st1[i] = 0;
      if (a == 6'(16 + i/8)) m_st2[i] = 0;
    end
  endtask

  task automatic step(logic [N-1:0] nv);
    logic [N-1:0] ev;
    @(negedge clk); evt_in = nv;
    repeat (4) @(negedge clk);
    for (int i = 0; i < N; i++)
      ev[i] = (nv[i] & ~m_prev[i] & m_edg[2*i+1]) | (~nv[i] & m_prev[i] & m_edg[2*i]);
    m_st1 |= ev & ~m_mk1;
    m_st2 |= ev & ~m_mk2;
    m_prev = nv;
    check_irq("R5 step");
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'd7;
    void'($urandom(seed));
    m_st1 = 0; m_st2 = 0; m_mk1 = '1; m_mk2 = '1; m_edg = 0; m_cor = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_irq("R4 reset");
    bus_rd("R4 mask1 reset", 6'h0C);
    bus_rd("R2 edge reset", 6'h19);
    bus_rd("R6 ctrl reset", 6'h00);
    bus_rd("R8 unmapped", 6'h0E);
    // R2: unmasked input with no edge enable never sets status
    bus_wr(6'h0C, 8'h00); bus_wr(6'h0D, 8'h00);
    step(16'h00FF); step(16'h0000);
    bus_rd("R2 no edge status", 6'h08);
    // R1: input 5 rising only -> byte 1 bit 3
    bus_wr(6'h19, 8'h08);
    bus_wr(6'h0C, 8'hDF); bus_wr(6'h0D, 8'hFF);
    step(16'h0020);
    bus_rd("R1 rise captured", 6'h08);
    bus_rd("R3 line2 masked", 6'h10);
    bus_rd("R10 primary l1", 6'h01);
    step(16'h0000);
    bus_rd("R1 fall ignored", 6'h08);
    // R7: read does not clear, write 0 keeps, write 1 clears
    bus_rd("R7 read keeps", 6'h08);
    bus_wr(6'h08, 8'h00); bus_rd("R7 zero write keeps", 6'h08);
    bus_wr(6'h08, 8'h20); bus_rd("R7 w1c clears", 6'h08);
    check_irq("R5 after clear");
    // R9: edge capture coinciding with W1C of the same bit (input 0, both edges)
    bus_wr(6'h18, 8'h03); bus_wr(6'h0C, 8'hDE);
    step(16'h0001);
    @(negedge clk); evt_in = 16'h0000;
    @(negedge clk);
    @(negedge clk); addr = 6'h08; wr_data = 8'h01; wr_en = 1;
    @(negedge clk); wr_en = 0; m_prev = 16'h0000;
    repeat (2) @(negedge clk);
    bus_rd("R9 event kept on clear", 6'h08);
    check_irq("R9 line held");
    // R6: clear-on-read
    bus_wr(6'h00, 8'h01);
    bus_wr(6'h08, 8'hFF); bus_rd("R6 write ignored", 6'h08);
    bus_rd("R6 read returns", 6'h08);
    bus_rd("R6 read cleared", 6'h08);
    // R4: all-ones mask silences line
    bus_wr(6'h0C, 8'hFF); bus_wr(6'h0D, 8'hFF);
    step(16'h0001);
    check_irq("R4 full mask");
    // random phase
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 9);
      peer_l1 = 8'($urandom); peer_l2 = 8'($urandom);
      case (op)
        0, 1, 2: step(16'($urandom));
        3: bus_wr(6'h0C + 6'($urandom_range(0, 1)), 8'($urandom));
        4: bus_wr(6'h14 + 6'($urandom_range(0, 1)), 8'($urandom));
        5: bus_wr(6'h18 + 6'($urandom_range(0, 3)), 8'($urandom));
        6: bus_wr(6'h00, 8'($urandom));
        7: bus_wr(($urandom_range(0, 1) ? 6'h08 : 6'h10) + 6'($urandom_range(0, 1)), 8'($urandom));
        8: bus_rd("R3 R6 R7 random status", ($urandom_range(0, 1) ? 6'h08 : 6'h10) + 6'($urandom_range(0, 1)));
        default: bus_rd("R8 R10 random reg", 6'($urandom_range(0, 31)));
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule